// File: doc/BRIEF.md
# Tournament Conditional-Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Two predictors run side by side. The per-branch predictor keeps a short outcome history for each branch slot and uses that history, mixed with address bits, to pick a 2-bit counter. The path predictor keeps one shift register of the most recent outcomes across all branches and mixes it with address bits to pick a counter in its own table. A third table of 2-bit counters, selected by address bits, decides which of the two answers is passed on to fetch. Each counter predicts taken when its value is 2 or 3.

The fetch stage presents a program counter and reads three bits in the same cycle: the chosen prediction and the two component predictions. It keeps these bits with the branch. When the branch resolves, the pipeline returns the address, the real outcome, the two component predictions and the prediction that was used. Both component counters and both histories are then trained, and the selector counter moves toward the component that was right when the two disagreed. Two running counts, one of queries and one of wrong predictions, measure accuracy.

Top module: `tournament_bp`

## Requirements
- R1: After reset, every component counter holds 1 (weakly not taken), every selector counter holds 2 (weakly favouring the path predictor), all histories are zero and both counts are zero, so every address predicts not taken.
- R2: A counter value of 2 or 3 predicts taken and 0 or 1 predicts not taken; a branch that is always taken comes to be predicted taken.
- R3: The per-branch history slot is chosen by PC bits [LHT_W+1:2]. The per-branch counter is chosen by that slot's history XOR PC bits [LHIST_W+1:2]. On resolution the slot's history shifts left with the outcome entering at bit 0.
- R4: The path history shifts left on every resolution with the outcome entering at bit 0, and holds otherwise. The path counter is chosen by the path history XOR PC bits [GHIST_W+1:2].
- R5: On every resolution both component counters, selected with the histories as they stand before that resolution, step toward the outcome and saturate at 0 and 3.
- R6: The selector counter is chosen by PC bits [CH_W+1:2]; a value of 2 or 3 selects the path predictor. When the returned component predictions differ it steps toward the correct one (up when the path predictor was right), saturating at 0 and 3; when they agree it is unchanged.
- R7: pred_taken equals the component prediction picked by the selector; when both components agree it equals them.
- R8: pred_count increases by one in each cycle with fetch_valid high and holds otherwise.
- R9: mispred_count increases by one on each resolution whose res_used_pred differs from res_taken and holds otherwise.
- R10: A fetch in the same cycle as a resolution reads the tables and histories as they were before that resolution's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | A prediction is being requested this cycle |
| fetch_pc | input | PC_W | Address of the branch being fetched |
| pred_taken | output | 1 | Chosen direction prediction |
| pred_local | output | 1 | Per-branch predictor's guess |
| pred_global | output | 1 | Path predictor's guess |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | PC_W | Address of the resolving branch |
| res_taken | input | 1 | Actual outcome |
| res_local_pred | input | 1 | Per-branch guess made at fetch |
| res_global_pred | input | 1 | Path guess made at fetch |
| res_used_pred | input | 1 | Prediction that fetch acted on |
| pred_count | output | CNT_W | Number of prediction requests |
| mispred_count | output | CNT_W | Number of wrong predictions |

## Verification
On every cycle the assertions check the path history shift and hold, that the selector entry stays put when both components agreed and never moves away from a correct path predictor, that the output follows the components when they agree, and the step behaviour of both counts. Whether the predictors actually learn (saturation, alternating patterns caught through per-branch history, outcomes correlated across two branches caught through path history, and the same-cycle read-before-update order) can only be shown by the bench's scenarios, where a behavioural model of the tables is compared with every output on every clock.

// File: rtl/tournament_bp.sv
module tournament_bp #(
  parameter int PC_W    = 32,
  parameter int LHT_W   = 6,
  parameter int LHIST_W = 6,
  parameter int GHIST_W = 8,
  parameter int CH_W    = 8,
  parameter int CNT_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_valid,
  input  logic [PC_W-1:0]  fetch_pc,
  output logic             pred_taken,
  output logic             pred_local,
  output logic             pred_global,
  input  logic             res_valid,
  input  logic [PC_W-1:0]  res_pc,
  input  logic             res_taken,
  input  logic             res_local_pred,
  input  logic             res_global_pred,
  input  logic             res_used_pred,
  output logic [CNT_W-1:0] pred_count,
  output logic [CNT_W-1:0] mispred_count
);

  localparam int LHT_N = 1 << LHT_W;
  localparam int LCT_N = 1 << LHIST_W;
  localparam int GCT_N = 1 << GHIST_W;
  localparam int CH_N  = 1 << CH_W;
  localparam int IW_A  = (LHT_W > LHIST_W) ? LHT_W : LHIST_W;
  localparam int IW_B  = (GHIST_W > CH_W) ? GHIST_W : CH_W;
  localparam int IW    = (IW_A > IW_B) ? IW_A : IW_B;

  logic [LHIST_W-1:0] lht [LHT_N];
  logic [1:0]         lct [LCT_N];
  logic [1:0]         gct [GCT_N];
  logic [1:0]         cht [CH_N];
  logic [GHIST_W-1:0] ghr;

  function automatic logic [1:0] bump(input logic [1:0] c, input logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  logic [LHT_W-1:0]   f_lh_i, r_lh_i;
  logic [LHIST_W-1:0] f_lc_i, r_lc_i;
  logic [GHIST_W-1:0] f_gc_i, r_gc_i;
  logic [CH_W-1:0]    f_ch_i, r_ch_i;

  assign f_lh_i = fetch_pc[LHT_W+1:2];
  assign f_lc_i = lht[f_lh_i] ^ fetch_pc[LHIST_W+1:2];
  assign f_gc_i = ghr ^ fetch_pc[GHIST_W+1:2];
  assign f_ch_i = fetch_pc[CH_W+1:2];

  assign r_lh_i = res_pc[LHT_W+1:2];
  assign r_lc_i = lht[r_lh_i] ^ res_pc[LHIST_W+1:2];
  assign r_gc_i = ghr ^ res_pc[GHIST_W+1:2];
  assign r_ch_i = res_pc[CH_W+1:2];

  assign pred_local  = lct[f_lc_i][1];
  assign pred_global = gct[f_gc_i][1];
  assign pred_taken  = cht[f_ch_i][1] ? pred_global : pred_local;

  logic unused_pc_bits;
  assign unused_pc_bits = ^{fetch_pc[PC_W-1:IW+2], fetch_pc[1:0], res_pc[PC_W-1:IW+2], res_pc[1:0]};

  logic disagree;
  assign disagree = res_local_pred != res_global_pred;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LHT_N; i++) lht[i] <= '0;
      for (int i = 0; i < LCT_N; i++) lct[i] <= 2'd1;
      for (int i = 0; i < GCT_N; i++) gct[i] <= 2'd1;
      for (int i = 0; i < CH_N; i++)  cht[i] <= 2'd2;
      ghr <= '0;
    end else if (res_valid) begin
      lht[r_lh_i] <= {lht[r_lh_i][LHIST_W-2:0], res_taken};
      lct[r_lc_i] <= bump(lct[r_lc_i], res_taken);
      gct[r_gc_i] <= bump(gct[r_gc_i], res_taken);
      ghr         <= {ghr[GHIST_W-2:0], res_taken};
      if (disagree) cht[r_ch_i] <= bump(cht[r_ch_i], res_global_pred == res_taken);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_count    <= '0;
      mispred_count <= '0;
    end else begin
      if (fetch_valid) pred_count <= pred_count + 1'b1;
      if (res_valid && (res_used_pred != res_taken)) mispred_count <= mispred_count + 1'b1;
    end
  end

  logic            chk_agree, chk_dis_g;
  logic [CH_W-1:0] chk_i;
  logic [1:0]      chk_v;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_agree <= 1'b0;
      chk_dis_g <= 1'b0;
      chk_i     <= '0;
      chk_v     <= 2'd0;
    end else begin
      chk_agree <= res_valid && !disagree;
      chk_dis_g <= res_valid && disagree && (res_global_pred == res_taken);
      chk_i     <= r_ch_i;
      chk_v     <= cht[r_ch_i];
    end
  end

  p_ghr_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> (ghr[0] == $past(res_taken)) && (ghr[GHIST_W-1:1] == $past(ghr[GHIST_W-2:0])));
  p_ghr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> $stable(ghr));
  p_chooser_agree_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chk_agree |-> cht[chk_i] == chk_v);
  p_chooser_toward_global_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chk_dis_g |-> (cht[chk_i] >= chk_v) && (cht[chk_i] != 2'd0));
  p_agree_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_local == pred_global) |-> (pred_taken == pred_local));
  p_pred_inc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |=> pred_count == $past(pred_count) + 1'b1);
  p_pred_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> $stable(pred_count));
  p_mis_inc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (res_used_pred != res_taken)) |=> mispred_count == $past(mispred_count) + 1'b1);
  p_mis_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && (res_used_pred != res_taken)) |=> $stable(mispred_count));

endmodule

// File: tb/tournament_bp_test.sv
module tournament_bp_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_valid = 1'b0, res_valid = 1'b0;
  logic [31:0] fetch_pc = '0, res_pc = '0;
  logic res_taken = 1'b0, res_local_pred = 1'b0, res_global_pred = 1'b0, res_used_pred = 1'b0;
  logic pred_taken, pred_local, pred_global;
  logic [31:0] pred_count, mispred_count;

  always #4 clk = ~clk;

  tournament_bp uut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .pred_taken(pred_taken), .pred_local(pred_local), .pred_global(pred_global),
    .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
    .res_local_pred(res_local_pred), .res_global_pred(res_global_pred),
    .res_used_pred(res_used_pred), .pred_count(pred_count), .mispred_count(mispred_count)
  );

  typedef struct { int pc; bit o; bit lp; bit gp; bit fp; } br_t;
  br_t q[$];

  int lhtm[64], lctm[64], gctm[256], chm[256];
  int ghm, npred, nmis;
  int checks = 0, failures = 0;
  bit done = 0;
  int lf = 12345;
  string phase = "R1";

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s [%s] %s actual=%0d expected=%0d", tag, phase, what, act, exp);
    end
  endtask

  function automatic int sat(int c, bit up);
    if (up) return (c < 3) ? c + 1 : 3;
    return (c > 0) ? c - 1 : 0;
  endfunction

  function automatic bit m_lp(int pc);
    return lctm[(lhtm[(pc >> 2) & 63] ^ (pc >> 2)) & 63] >= 2;
  endfunction
  function automatic bit m_gp(int pc);
    return gctm[(ghm ^ (pc >> 2)) & 255] >= 2;
  endfunction
  function automatic bit m_fp(int pc);
    return (chm[(pc >> 2) & 255] >= 2) ? m_gp(pc) : m_lp(pc);
  endfunction

  function automatic void m_resolve(br_t e);
    int li, lci, gi, ci;
    li  = (e.pc >> 2) & 63;
    lci = (lhtm[li] ^ (e.pc >> 2)) & 63;
    gi  = (ghm ^ (e.pc >> 2)) & 255;
    ci  = (e.pc >> 2) & 255;
    lctm[lci] = sat(lctm[lci], e.o);
    gctm[gi]  = sat(gctm[gi], e.o);
    if (e.lp != e.gp) chm[ci] = sat(chm[ci], e.gp == e.o);
    lhtm[li] = ((lhtm[li] << 1) | e.o) & 63;
    ghm = ((ghm << 1) | e.o) & 255;
    if (e.fp != e.o) nmis++;
  endfunction

  task automatic cyc(bit fv, int pc, bit o, int depth);
    br_t e, r;
    bit rv;
    @(negedge clk);
    fetch_valid = fv;
    fetch_pc = pc;
    if (fv) begin
      e.pc = pc; e.o = o; e.lp = m_lp(pc); e.gp = m_gp(pc); e.fp = m_fp(pc);
      q.push_back(e);
    end
    rv = (q.size() > depth);
    if (rv) r = q.pop_front();
    res_valid = rv;
    res_pc = rv ? r.pc : 0;
    res_taken = rv ? r.o : 1'b0;
    res_local_pred = rv ? r.lp : 1'b0;
    res_global_pred = rv ? r.gp : 1'b0;
    res_used_pred = rv ? r.fp : 1'b0;
    #1;
    chk(pred_local == m_lp(pc), "R3 R5", "pred_local", pred_local, m_lp(pc));
    chk(pred_global == m_gp(pc), "R4 R5", "pred_global", pred_global, m_gp(pc));
    chk(pred_taken == m_fp(pc), "R6 R7 R10", "pred_taken", pred_taken, m_fp(pc));
    chk(pred_count == npred, "R8", "pred_count", pred_count, npred);
    chk(mispred_count == nmis, "R9", "mispred_count", mispred_count, nmis);
    @(posedge clk);
    if (fv) npred++;
    if (rv) m_resolve(r);
  endtask

  function automatic bit rbit();
    lf = (lf * 1103515245 + 12345) & 32'h7fffffff;
    return lf[16];
  endfunction

  initial begin
    bit last_a;
    for (int i = 0; i < 64; i++) begin lhtm[i] = 0; lctm[i] = 1; end
    for (int i = 0; i < 256; i++) begin gctm[i] = 1; chm[i] = 2; end
    ghm = 0; npred = 0; nmis = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    phase = "R1";
    foreach (lhtm[k]) if (k < 3) begin
      @(negedge clk);
      fetch_pc = 32'h40 + k * 32'h1234;
      #1;
      chk(pred_taken == 0 && pred_local == 0 && pred_global == 0, "R1", "reset prediction", pred_taken, 0);
      chk(pred_count == 0 && mispred_count == 0, "R1", "reset counts", pred_count + mispred_count, 0);
    end

    phase = "R2";
    for (int i = 0; i < 40; i++) cyc(1, 32'h100, 1, 2);
    for (int i = 0; i < 4; i++) cyc(0, 32'h100, 0, 0);
    @(negedge clk); fetch_pc = 32'h100; #1;
    chk(pred_taken == 1, "R2", "always-taken branch learned", pred_taken, 1);

    phase = "R5";
    for (int i = 0; i < 6; i++) cyc(1, 32'h100, (i == 2), 1);
    for (int i = 0; i < 3; i++) cyc(0, 32'h100, 0, 0);

    phase = "R3";
    for (int i = 0; i < 80; i++) begin
      cyc(1, 32'h204, i[0], 2);
      if (i % 7 == 0) cyc(0, 32'h204, 0, 2);
    end
    for (int i = 0; i < 3; i++) cyc(0, 32'h204, 0, 0);

    phase = "R4";
    last_a = 0;
    for (int i = 0; i < 120; i++) begin
      bit a;
      a = rbit();
      cyc(1, 32'h300, a, 1);
      cyc(1, 32'h344, a, 1);
      last_a = a;
    end
    for (int i = 0; i < 2; i++) cyc(0, 32'h344, last_a, 0);

    phase = "R6";
    for (int i = 0; i < 200; i++) begin
      int pc;
      pc = 32'h1000 + ((i % 5) << 2) * 9;
      cyc(1, pc, (i % 5 == 1) ? rbit() : ((i % 5) != 3), 3);
    end
    for (int i = 0; i < 4; i++) cyc(0, 32'h1000, 0, 0);

    phase = "R10";
    for (int i = 0; i < 60; i++) cyc(1, 32'h88, (i % 3) != 0, 0);
    cyc(0, 32'h88, 0, 0);

    @(negedge clk); #1;
    chk(pred_count == npred, "R8", "final pred_count", pred_count, npred);
    chk(mispred_count == nmis, "R9", "final mispred_count", mispred_count, nmis);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule